// File: doc/BRIEF.md
# Registered Word-Pair Bus Exchanger

This block joins one narrow data port to a pair of ports of the same width, and every transfer is clocked. Words that arrive on the narrow side go into one of two lane registers, or into both. Each lane has its own active-low load strobe. Two narrow words sent on successive clocks, each with its own strobe, therefore end up side by side and form one double-width word. In the other direction a single return register takes, at every edge, whichever of the two wide-side inputs the select line picks. It presents that value on the narrow side.

Each of the three ports has an active-low drive request, and this request is registered too. The block never drives a real three-state pin. Instead each port gives a data vector together with a registered drive flag, and the pad ring or bus fabric outside turns that pair into real drivers. Without reset the drive flags are unknown until the first clock edge. The `HAS_RESET` parameter adds a synchronous reset that only silences the drive flags.

Top module: `word_pair_exchanger`

## Requirements
- R1: On a rising edge where `ld1_n` is 0, `b1_out` shows the `a_in` value sampled at that edge, starting just after the edge. Two words loaded on successive edges, first with (`ld1_n`,`ld2_n`)=(0,1) and then with (1,0), read back as {`b2_out`,`b1_out`} = {second, first}.
- R2: On a rising edge where `ld2_n` is 0, `b2_out` shows the `a_in` value sampled at that edge.
- R3: A lane whose load strobe is 1 at an edge keeps its previous value across that edge.
- R4: When both strobes are 0 at the same edge, both lanes take the same `a_in` word.
- R5: At every rising edge the return register loads `b1_in` if `sel_b1` is 1 and `b2_in` if `sel_b1` is 0. `a_out` shows that value until the next edge.
- R6: Outside reset, each drive flag (`a_oe`, `b1_oe`, `b2_oe`, where 1 means driving) equals the inverse of its request (`a_en_n`, `b1_en_n`, `b2_en_n`) sampled at the previous rising edge. A change in a request therefore shows after exactly one edge.
- R7: With `HAS_RESET`=1, `rst` at 1 at an edge sets all three drive flags to 0 after that edge, whatever the requests are. Lane and return data still load as usual at that edge.
- R8: Loading and driving do not depend on each other. A lane loads while its drive flag is 0, and its data output carries the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the drive flags (used only when HAS_RESET=1) |
| a_in | input | W | Narrow-side input word |
| b1_in | input | W | First wide-side lane input |
| b2_in | input | W | Second wide-side lane input |
| ld1_n | input | 1 | Active-low load strobe of lane 1 |
| ld2_n | input | 1 | Active-low load strobe of lane 2 |
| sel_b1 | input | 1 | Return source: 1 picks lane 1 input, 0 picks lane 2 input |
| a_en_n | input | 1 | Active-low drive request, narrow side |
| b1_en_n | input | 1 | Active-low drive request, lane 1 |
| b2_en_n | input | 1 | Active-low drive request, lane 2 |
| a_out | output | W | Return register contents |
| a_oe | output | 1 | Registered drive flag, narrow side |
| b1_out | output | W | Lane 1 register contents |
| b1_oe | output | 1 | Registered drive flag, lane 1 |
| b2_out | output | W | Lane 2 register contents |
| b2_oe | output | 1 | Registered drive flag, lane 2 |

## Verification
Two things can happen on the same edge: a reset that silences the drive flags, and a lane load. Reset must turn the drivers off without dropping the word. The bench asserts `rst` together with a lane-1 strobe and active drive requests. After that edge it expects all three flags at 0 and the new word in lane 1. A seeded random stretch also raises reset now and then while loads and select changes go on, and the scoreboard judges each edge on its own.

// File: rtl/wpx_pkg.sv
package wpx_pkg;

    localparam int unsigned LANE_W  = 12;
    localparam int unsigned N_LANES = 2;

    // One registered drive flag per port, 1 = port drives its data
    typedef struct packed {
        logic a;
        logic b1;
        logic b2;
    } drive_t;

    localparam drive_t DRIVE_OFF = '{a: 1'b0, b1: 1'b0, b2: 1'b0};

    function automatic drive_t drive_from_req_n(input logic a_n, input logic b1_n, input logic b2_n);
        drive_t d;
        d.a  = ~a_n;
        d.b1 = ~b1_n;
        d.b2 = ~b2_n;
        return d;
    endfunction

endpackage

// File: rtl/wpx_lane_reg.sv
module wpx_lane_reg #(
    parameter int unsigned W = wpx_pkg::LANE_W
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!load_n) begin
            q <= d;
        end
    end

endmodule

// File: rtl/wpx_return_reg.sv
module wpx_return_reg #(
    parameter int unsigned W = wpx_pkg::LANE_W
) (
    input  logic         clk,
    input  logic         pick_first,
    input  logic [W-1:0] first_in,
    input  logic [W-1:0] second_in,
    output logic [W-1:0] q
);

    logic [W-1:0] chosen;

    always_comb begin
        chosen = pick_first ? first_in : second_in;
    end

    always_ff @(posedge clk) begin
        q <= chosen;
    end

endmodule

// File: rtl/wpx_drive_ctl.sv
module wpx_drive_ctl
    import wpx_pkg::*;
#(
    parameter bit HAS_RESET = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  drive_t req,
    output drive_t q
);

    generate
        if (HAS_RESET) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= DRIVE_OFF;
                end else begin
                    q <= req;
                end
            end
        end else begin : g_norst
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                q <= req;
            end
        end
    endgenerate

endmodule

// File: rtl/word_pair_exchanger.sv
module word_pair_exchanger
    import wpx_pkg::*;
#(
    parameter int unsigned W         = LANE_W,
    parameter bit          HAS_RESET = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         ld1_n,
    input  logic         ld2_n,
    input  logic         sel_b1,
    input  logic         a_en_n,
    input  logic         b1_en_n,
    input  logic         b2_en_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    output logic [W-1:0] b2_out,
    output logic         b2_oe
);

    localparam int unsigned LANES = N_LANES;

    logic [LANES-1:0] load_n_vec;
    logic [W-1:0]     lane_q [LANES];
    drive_t           drive_req;
    drive_t           drive_q;

    assign load_n_vec = {ld2_n, ld1_n};

    // Forward direction: one lane register per wide-side port
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            wpx_lane_reg #(.W(W)) u_lane (
                .clk    (clk),
                .load_n (load_n_vec[g]),
                .d      (a_in),
                .q      (lane_q[g])
            );
        end
    endgenerate

    assign b1_out = lane_q[0];
    assign b2_out = lane_q[1];

    // Return direction: single register fed by the selected lane input
    wpx_return_reg #(.W(W)) u_return (
        .clk        (clk),
        .pick_first (sel_b1),
        .first_in   (b1_in),
        .second_in  (b2_in),
        .q          (a_out)
    );

    // Registered drive flags
    assign drive_req = drive_from_req_n(a_en_n, b1_en_n, b2_en_n);

    wpx_drive_ctl #(.HAS_RESET(HAS_RESET)) u_drive (
        .clk (clk),
        .rst (rst),
        .req (drive_req),
        .q   (drive_q)
    );

    assign a_oe  = drive_q.a;
    assign b1_oe = drive_q.b1;
    assign b2_oe = drive_q.b2;

endmodule

// File: rtl/wpx_checker.sv
module wpx_checker #(
    parameter int unsigned W         = 12,
    parameter bit          HAS_RESET = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b2_in,
    input logic         ld1_n,
    input logic         ld2_n,
    input logic         sel_b1,
    input logic         a_en_n,
    input logic         b1_en_n,
    input logic         b2_en_n,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b1_out,
    input logic         b1_oe,
    input logic [W-1:0] b2_out,
    input logic         b2_oe
);

    // R1
    lane1_load_chk: assert property (@(posedge clk) disable iff (rst)
        !ld1_n |=> b1_out == $past(a_in));

    // R2
    lane2_load_chk: assert property (@(posedge clk) disable iff (rst)
        !ld2_n |=> b2_out == $past(a_in));

    // R3
    lane1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ld1_n |=> $stable(b1_out));

    // R3
    lane2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ld2_n |=> $stable(b2_out));

    // R4
    dual_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld1_n && !ld2_n) |=> b1_out == b2_out);

    // R5
    return_first_chk: assert property (@(posedge clk) disable iff (rst)
        sel_b1 |=> a_out == $past(b1_in));

    // R5
    return_second_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_b1 |=> a_out == $past(b2_in));

    // R6
    a_drive_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> a_oe == !$past(a_en_n));

    // R6
    b1_drive_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b1_oe == !$past(b1_en_n));

    // R6
    b2_drive_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> b2_oe == !$past(b2_en_n));

    generate
        if (HAS_RESET) begin : g_rst_chk
            // R7
            reset_quiet_chk: assert property (@(posedge clk)
                rst |=> (!a_oe && !b1_oe && !b2_oe));
        end
    endgenerate

endmodule

bind word_pair_exchanger wpx_checker #(.W(W), .HAS_RESET(HAS_RESET)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b1_in   (b1_in),
    .b2_in   (b2_in),
    .ld1_n   (ld1_n),
    .ld2_n   (ld2_n),
    .sel_b1  (sel_b1),
    .a_en_n  (a_en_n),
    .b1_en_n (b1_en_n),
    .b2_en_n (b2_en_n),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b1_out  (b1_out),
    .b1_oe   (b1_oe),
    .b2_out  (b2_out),
    .b2_oe   (b2_oe)
);

// File: tb/word_pair_exchanger_tb_top.sv
module word_pair_exchanger_tb_top;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         ld1_n = 1'b1, ld2_n = 1'b1, sel_b1 = 1'b0;
    logic         a_en_n = 1'b1, b1_en_n = 1'b1, b2_en_n = 1'b1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;

    always #10 clk = ~clk;

    word_pair_exchanger #(.W(W), .HAS_RESET(1'b1)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b1_in(b1_in), .b2_in(b2_in),
        .ld1_n(ld1_n), .ld2_n(ld2_n), .sel_b1(sel_b1),
        .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n),
        .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_out(b2_out), .b2_oe(b2_oe)
    );

    // kind: 0 drive flags {a,b1,b2}, 1 lane 1, 2 lane 2, 3 return, 4 {lane2,lane1}
    typedef struct {
        int             kind;
        logic [2*W-1:0] exp;
        string          tag;
    } item_t;

    item_t        sbq[$];
    int           checks = 0;
    int           errors = 0;
    bit           done   = 0;
    logic [W-1:0] m_b1, m_b2, m_a;
    bit           v_b1 = 0, v_b2 = 0;
    logic [2:0]   m_oe;

    task automatic push(input int kind, input logic [2*W-1:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    // Driver: applies one edge of stimulus and queues what must show after it
    task automatic drive(input logic r, input logic [W-1:0] a, input logic [W-1:0] b1,
                         input logic [W-1:0] b2, input logic l1n, input logic l2n,
                         input logic s, input logic ean, input logic eb1n, input logic eb2n);
        @(negedge clk);
        rst = r; a_in = a; b1_in = b1; b2_in = b2;
        ld1_n = l1n; ld2_n = l2n; sel_b1 = s;
        a_en_n = ean; b1_en_n = eb1n; b2_en_n = eb2n;
        if (!l1n) begin m_b1 = a; v_b1 = 1; end
        if (!l2n) begin m_b2 = a; v_b2 = 1; end
        m_a  = s ? b1 : b2;
        m_oe = r ? 3'b000 : {~ean, ~eb1n, ~eb2n};
        push(0, {{(2*W-3){1'b0}}, m_oe}, r ? "R7" : "R6");
        if (v_b1) push(1, {{W{1'b0}}, m_b1},
                       l1n ? "R3" : (!l2n ? "R4" : (eb1n ? "R8" : "R1")));
        if (v_b2) push(2, {{W{1'b0}}, m_b2},
                       l2n ? "R3" : (!l1n ? "R4" : (eb2n ? "R8" : "R2")));
        push(3, {{W{1'b0}}, m_a}, "R5");
    endtask

    // Monitor: compares everything queued for the edge just taken
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sbq.size() > 0) begin
                item_t          it;
                logic [2*W-1:0] act;
                it  = sbq.pop_front();
                act = '0;
                case (it.kind)
                    0: act[2:0]   = {a_oe, b1_oe, b2_oe};
                    1: act[W-1:0] = b1_out;
                    2: act[W-1:0] = b2_out;
                    3: act[W-1:0] = a_out;
                    default: act  = {b2_out, b1_out};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset with drive requests active: flags must stay off (R7)
        drive(1, 12'h000, 12'h001, 12'h002, 1, 1, 1, 0, 0, 0);
        // Reset coinciding with a lane 1 load: word lands, flags off (R7, R1)
        drive(1, 12'h5A5, 12'h003, 12'h004, 0, 1, 0, 0, 0, 0);
        // Leave reset with all requests inactive (R6)
        drive(0, 12'h000, 12'h0F0, 12'h00F, 1, 1, 1, 1, 1, 1);
        // Two words with strobes (0,1) then (1,0), ports quiet (R8)
        drive(0, 12'hA5C, 12'h111, 12'h222, 0, 1, 1, 1, 1, 1);
        drive(0, 12'h3E7, 12'h333, 12'h444, 1, 0, 0, 1, 1, 1);
        push(4, {12'h3E7, 12'hA5C}, "R1");
        // Both hold, drive turned on (R3, R6)
        drive(0, 12'hFFF, 12'h555, 12'h666, 1, 1, 1, 0, 0, 0);
        push(4, {12'h3E7, 12'hA5C}, "R3");
        // Both strobes low (R4)
        drive(0, 12'h9C3, 12'h777, 12'h888, 0, 0, 0, 0, 0, 0);
        // Single-port drive toggles show one edge later (R6)
        drive(0, 12'h001, 12'hABC, 12'hDEF, 1, 1, 1, 0, 1, 1);
        drive(0, 12'h002, 12'hABC, 12'hDEF, 1, 1, 0, 1, 0, 1);
        drive(0, 12'h003, 12'hABC, 12'hDEF, 1, 1, 1, 1, 1, 0);
        // Separate loads with drive on (R1, R2)
        drive(0, 12'h1D2, 12'h010, 12'h020, 0, 1, 1, 0, 0, 0);
        drive(0, 12'h2E3, 12'h030, 12'h040, 1, 0, 0, 0, 0, 0);
        // Seeded mixed traffic with occasional reset
        for (int i = 0; i < 80; i++) begin
            logic [7:0] ctl;
            ctl = 8'($urandom);
            drive(ctl[7:5] == 3'b000, 12'($urandom), 12'($urandom), 12'($urandom),
                  ctl[0], ctl[1], ctl[2], ctl[3], ctl[4], ctl[5]);
        end
        drive(0, 12'h000, 12'h000, 12'h000, 1, 1, 0, 1, 1, 1);
        @(posedge clk);
        @(posedge clk);
        #6;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule